// File: doc/BRIEF.md
# Loadable Transfer Length Counter

This block holds the byte count for one DMA transfer. Software programs the count one byte at a time into a written (shadow) copy. Three byte lanes, low, middle and high, form a 24-bit value. A command strobe that carries the DMA flag copies the shadow copy into a live copy and enables DMA mode. The live copy is the one that reads return. A command strobe without the flag leaves DMA mode and does not change the live copy.

When a transfer starts, the block works out the effective length. This is the live count, with a zero count taken as 65536, limited to the data size the requester still has available. The block loads this length into a down-counter that one beat input decrements per byte moved. When the counter reaches zero, the block clears the live count and sets a count-zero flag. The flag drops again on a new start or on any write to a count byte.

Until the high count byte has been written after reset, a read of that lane returns a fixed identification constant. After the first write, the read returns the stored live value.

Top module: `tcnt_top`

## Requirements
- R1: The live count is the value lane0 + lane1·256 + lane2·65536, where lane 0 is the low byte (wr_sel/rd_sel = 0), lane 1 is the middle byte (1) and lane 2 is the high byte (2). A start uses this value.
- R2: A write with wr_sel 0, 1 or 2 clears tc after the clock edge, unless a completion happens in the same cycle. A write with wr_sel = 3 changes nothing.
- R3: Writes update only the shadow copy. A cmd_valid strobe with cmd_dma=1 copies all three shadow bytes into the live bytes and sets dma_mode. A strobe with cmd_dma=0 clears dma_mode and leaves the live bytes unchanged.
- R4: A live count of zero is treated as 65536 when a transfer starts.
- R5: On an accepted start, xfer_len and xfer_left both become the smaller of the (R4-adjusted) count and avail, one cycle later.
- R6: rd_data is registered, so it shows the lane picked by rd_sel in the previous cycle. Lane 2 reads as CHIP_ID (default 0x12) until lane 2 has been written since reset, and as the live byte after that. rd_sel = 3 reads 0.
- R7: When xfer_left goes from 1 to 0 on a beat, or a start yields an effective length of 0, the live bytes become zero and tc is set, one cycle later.
- R8: An accepted start clears tc. Each beat with xfer_left > 0 decrements xfer_left by one. A beat with xfer_left = 0 is ignored.
- R9: A start while dma_mode = 0 is ignored: xfer_len, xfer_left and tc do not change.
- R10: After a synchronous reset, all shadow and live bytes, xfer_len, xfer_left, tc, dma_mode and rd_data are zero, and the high-byte-written flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Count byte write strobe |
| wr_sel | input | 2 | Byte lane to write (0 low, 1 middle, 2 high) |
| wr_data | input | 8 | Write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| rd_sel | input | 2 | Byte lane to read |
| rd_data | output | 8 | Registered read data |
| start | input | 1 | Start a transfer |
| avail | input | 24 | Remaining data size in the current direction |
| beat | input | 1 | One byte moved |
| dma_mode | output | 1 | DMA mode is set |
| xfer_len | output | 24 | Effective length of the last accepted start |
| xfer_left | output | 24 | Bytes still to move |
| tc | output | 1 | Count-zero (terminal count) flag |

## Verification
The assertions check these on every cycle: the decrement by one per beat, completion setting tc with xfer_left at zero, write-driven clearing of tc, dma_mode following a command without the flag, and xfer_left never exceeding xfer_len and xfer_len never exceeding avail after a start. The following can only be shown by the bench scenarios, which read the lanes back and compare against a reference model: the shadow/live split, the 65536 substitution for a zero count, the full 24-bit lane composition, the identification value before the first high-byte write, and the zeroing of the live bytes on completion.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  typedef enum logic [1:0] {
    LANE_LO  = 2'd0,
    LANE_MID = 2'd1,
    LANE_HI  = 2'd2,
    LANE_NONE = 2'd3
  } lane_e;

  function automatic logic [31:0] min32(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/tcnt_bytes.sv
module tcnt_bytes #(
  parameter int NBYTES = 3,
  parameter int BW     = 8,
  parameter int SELW   = 2,
  localparam int CW    = NBYTES * BW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [BW-1:0]   wr_data,
  input  logic            reload,
  input  logic            zero,
  output logic [CW-1:0]   live,
  output logic            hi_written
);
  logic [CW-1:0] shadow;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        shadow[i*BW +: BW] <= '0;
      else if (wr_en && wr_sel == SELW'(i))
        shadow[i*BW +: BW] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst || zero)
        live[i*BW +: BW] <= '0;
      else if (reload)
        live[i*BW +: BW] <= shadow[i*BW +: BW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      hi_written <= 1'b0;
    else if (wr_en && wr_sel == SELW'(NBYTES-1))
      hi_written <= 1'b1;
  end
endmodule

// File: rtl/tcnt_len.sv
module tcnt_len #(
  parameter int CW       = 24,
  parameter int ZERO_LEN = 65536
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] avail,
  output logic [CW-1:0] eff
);
  import tcnt_pkg::*;
  logic [CW-1:0] adj;

  always_comb begin
    adj = (count == '0) ? CW'(ZERO_LEN) : count;
    eff = CW'(min32(32'(adj), 32'(avail)));
  end
endmodule

// File: rtl/tcnt_down.sv
module tcnt_down #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [CW-1:0] eff,
  input  logic          beat,
  input  logic          wr_hit,
  output logic          done,
  output logic [CW-1:0] xfer_len,
  output logic [CW-1:0] xfer_left,
  output logic          tc
);
  always_comb begin
    if (go)
      done = (eff == '0);
    else
      done = beat && (xfer_left == CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_len  <= '0;
      xfer_left <= '0;
    end else if (go) begin
      xfer_len  <= eff;
      xfer_left <= eff;
    end else if (beat && xfer_left != '0) begin
      xfer_left <= xfer_left - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      tc <= 1'b0;
    else if (done)
      tc <= 1'b1;
    else if (go || wr_hit)
      tc <= 1'b0;
  end
endmodule

// File: rtl/tcnt_top.sv
module tcnt_top #(
  parameter int NBYTES   = 3,
  parameter int BW       = 8,
  parameter int ZERO_LEN = 65536,
  parameter logic [7:0] CHIP_ID = 8'h12,
  localparam int SELW    = $clog2(NBYTES + 1),
  localparam int CW      = NBYTES * BW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [BW-1:0]   wr_data,
  input  logic            cmd_valid,
  input  logic            cmd_dma,
  input  logic [SELW-1:0] rd_sel,
  output logic [BW-1:0]   rd_data,
  input  logic            start,
  input  logic [CW-1:0]   avail,
  input  logic            beat,
  output logic            dma_mode,
  output logic [CW-1:0]   xfer_len,
  output logic [CW-1:0]   xfer_left,
  output logic            tc
);
  logic [CW-1:0] live;
  logic [CW-1:0] eff;
  logic          hi_written;
  logic          done;
  logic          go;
  logic          wr_hit;
  logic          reload;
  logic [BW-1:0] rd_next;

  assign go     = start && dma_mode;
  assign wr_hit = wr_en && (int'(wr_sel) < NBYTES);
  assign reload = cmd_valid && cmd_dma;

  tcnt_bytes #(.NBYTES(NBYTES), .BW(BW), .SELW(SELW)) u_bytes (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .reload(reload), .zero(done), .live(live), .hi_written(hi_written)
  );

  tcnt_len #(.CW(CW), .ZERO_LEN(ZERO_LEN)) u_len (
    .count(live), .avail(avail), .eff(eff)
  );

  tcnt_down #(.CW(CW)) u_down (
    .clk(clk), .rst(rst), .go(go), .eff(eff), .beat(beat), .wr_hit(wr_hit),
    .done(done), .xfer_len(xfer_len), .xfer_left(xfer_left), .tc(tc)
  );

  always_ff @(posedge clk) begin
    if (rst)
      dma_mode <= 1'b0;
    else if (cmd_valid)
      dma_mode <= cmd_dma;
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NBYTES; i++)
      if (int'(rd_sel) == i)
        rd_next = live[i*BW +: BW];
    if (int'(rd_sel) == NBYTES - 1 && !hi_written)
      rd_next = BW'(CHIP_ID);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      rd_data <= rd_next;
  end
endmodule

// File: rtl/tcnt_chk.sv
module tcnt_chk #(
  parameter int NBYTES = 3,
  parameter int BW     = 8,
  parameter int SELW   = 2,
  parameter int CW     = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [SELW-1:0] wr_sel,
  input logic            cmd_valid,
  input logic            cmd_dma,
  input logic            start,
  input logic [CW-1:0]   avail,
  input logic            beat,
  input logic            dma_mode,
  input logic [CW-1:0]   xfer_len,
  input logic [CW-1:0]   xfer_left,
  input logic            tc
);
  p_write_clears_tc_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_sel) < NBYTES && !beat && !start) |=> !tc);

  p_nodma_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_dma) |=> !dma_mode);

  p_len_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (start && dma_mode) |=> (xfer_len <= $past(avail)));

  p_done_sets_tc_r7: assert property (@(posedge clk) disable iff (rst)
    (beat && !start && xfer_left == CW'(1)) |=> (tc && xfer_left == '0));

  p_beat_dec_r8: assert property (@(posedge clk) disable iff (rst)
    (beat && !start && xfer_left > CW'(1)) |=> (xfer_left == $past(xfer_left) - CW'(1)));

  p_left_bound_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_left <= xfer_len);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !dma_mode && !beat && !wr_en) |=> ($stable(xfer_len) && $stable(xfer_left) && $stable(tc)));
endmodule

bind tcnt_top tcnt_chk #(.NBYTES(NBYTES), .BW(BW), .SELW(SELW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .cmd_valid(cmd_valid),
  .cmd_dma(cmd_dma), .start(start), .avail(avail), .beat(beat), .dma_mode(dma_mode),
  .xfer_len(xfer_len), .xfer_left(xfer_left), .tc(tc)
);

// File: tb/sim_tcnt_top.sv
`timescale 1ns/1ps
module sim_tcnt_top;
  localparam int ID = 'h12;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [7:0]  wr_data = 0;
  logic        cmd_valid = 0;
  logic        cmd_dma = 0;
  logic [1:0]  rd_sel = 0;
  logic [7:0]  rd_data;
  logic        start = 0;
  logic [23:0] avail = 0;
  logic        beat = 0;
  logic        dma_mode;
  logic [23:0] xfer_len;
  logic [23:0] xfer_left;
  logic        tc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  int m_sh[3];
  int m_lv[3];
  int m_hiw, m_tc, m_dma, m_len, m_left, m_rd;
  int t_cnt, t_eff, t_pre_left, t_go, t_done;

  always #10 clk = ~clk;

  tcnt_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .rd_sel(rd_sel), .rd_data(rd_data),
    .start(start), .avail(avail), .beat(beat), .dma_mode(dma_mode),
    .xfer_len(xfer_len), .xfer_left(xfer_left), .tc(tc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_lv[i] = 0; end
      m_hiw = 0; m_tc = 0; m_dma = 0; m_len = 0; m_left = 0; m_rd = 0;
    end else begin
      if (rd_sel == 2 && m_hiw == 0) m_rd = ID;
      else if (rd_sel < 3) m_rd = m_lv[rd_sel];
      else m_rd = 0;
      t_cnt = m_lv[0] + m_lv[1] * 256 + m_lv[2] * 65536;
      t_go = (start && m_dma != 0) ? 1 : 0;
      t_pre_left = m_left;
      t_done = 0;
      if (cmd_valid) begin
        m_dma = cmd_dma;
        if (cmd_dma) for (int i = 0; i < 3; i++) m_lv[i] = m_sh[i];
      end
      if (wr_en && wr_sel < 3) begin
        m_sh[wr_sel] = wr_data;
        if (wr_sel == 2) m_hiw = 1;
        m_tc = 0;
      end
      if (t_go != 0) begin
        t_eff = (t_cnt == 0) ? 65536 : t_cnt;
        if (int'(avail) < t_eff) t_eff = avail;
        m_len = t_eff; m_left = t_eff; m_tc = 0;
        t_done = (t_eff == 0) ? 1 : 0;
      end else if (beat && t_pre_left > 0) begin
        m_left = m_left - 1;
        t_done = (m_left == 0) ? 1 : 0;
      end
      if (t_done != 0) begin
        for (int i = 0; i < 3; i++) m_lv[i] = 0;
        m_tc = 1;
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R6 rd_data", rd_data, m_rd);
      chk("R5 xfer_len", xfer_len, m_len);
      chk("R8 xfer_left", xfer_left, m_left);
      chk("R7 tc", tc, m_tc);
      chk("R3 dma_mode", dma_mode, m_dma);
    end
  end

  task automatic idle();
    wr_en = 0; cmd_valid = 0; start = 0; beat = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic wr(input int sel, input int d);
    wr_en = 1; wr_sel = sel[1:0]; wr_data = d[7:0]; step();
  endtask

  task automatic cmd(input bit dma);
    cmd_valid = 1; cmd_dma = dma; step();
  endtask

  task automatic go(input int av);
    start = 1; avail = av[23:0]; step();
  endtask

  task automatic beats(input int n);
    for (int i = 0; i < n; i++) begin beat = 1; step(); end
  endtask

  task automatic rd(input int sel, output int v);
    rd_sel = sel[1:0]; step(); v = rd_data;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 xfer_len", xfer_len, 0);
    chk("R10 xfer_left", xfer_left, 0);
    chk("R10 tc", tc, 0);
    chk("R10 dma_mode", dma_mode, 0);
    chk("R10 rd_data", rd_data, 0);

    // R6 id before high byte written, lane 3 reads zero
    rd(2, v); chk("R6 id before write", v, ID);
    rd(3, v); chk("R6 lane3", v, 0);

    // R9 start without DMA mode ignored
    go(5);
    chk("R9 len", xfer_len, 0); chk("R9 tc", tc, 0);

    // R3 shadow only until reload
    wr(0, 'h34); wr(1, 'h12); wr(2, 'h00);
    rd(0, v); chk("R3 live unchanged", v, 0);
    rd(2, v); chk("R6 after write", v, 0);
    cmd(1);
    chk("R3 dma set", dma_mode, 1);
    rd(0, v); chk("R3 reload lo", v, 'h34);
    rd(1, v); chk("R3 reload mid", v, 'h12);

    // R5 avail smaller than count, R7 completion
    go('h100);
    chk("R5 len", xfer_len, 'h100);
    beats(3);
    chk("R8 left", xfer_left, 'hFD);
    beats('hFD);
    chk("R7 tc set", tc, 1);
    chk("R7 left zero", xfer_left, 0);
    rd(0, v); chk("R7 live zeroed", v, 0);
    beats(1);
    chk("R8 beat at zero", xfer_left, 0);

    // R2 write clears tc; lane 3 write does not
    wr(3, 'h55);
    chk("R2 lane3 keeps tc", tc, 1);
    wr(0, 'h00);
    chk("R2 tc cleared", tc, 0);

    // R4 zero count taken as 65536
    wr(1, 0); wr(2, 0);
    cmd(1);
    go('h20000);
    chk("R4 len 65536", xfer_len, 'h10000);
    beats(2);
    go(3);
    chk("R5 restart len", xfer_len, 3);
    beats(3);
    chk("R7 tc after restart", tc, 1);

    // R1 full 24-bit composition; R8 start clears tc
    wr(0, 'h05); wr(1, 'h00); wr(2, 'h02);
    cmd(1);
    go('hFFFFFF);
    chk("R1 len composed", xfer_len, 'h020005);
    chk("R8 start clears tc", tc, 0);
    rd(2, v); chk("R1 hi lane", v, 'h02);
    beats(4);

    // R3 non-DMA command keeps live bytes, R9 start then ignored
    cmd(0);
    chk("R3 dma cleared", dma_mode, 0);
    rd(0, v); chk("R3 live kept", v, 'h05);
    go(7);
    chk("R9 len kept", xfer_len, 'h020005);

    // R7 start with zero available completes at once
    cmd(1);
    go(0);
    chk("R7 zero avail tc", tc, 1);
    rd(2, v); chk("R7 zero avail live", v, 0);

    // mixed traffic compared by the model
    for (int k = 0; k < 300; k++) begin
      wr_en = (k % 7 == 0); wr_sel = 2'(k % 4); wr_data = 8'(k * 13);
      cmd_valid = (k % 11 == 0); cmd_dma = (k % 3 != 0);
      start = (k % 17 == 0); avail = 24'(k % 40);
      beat = (k % 2 == 0); rd_sel = 2'(k % 4);
      step();
    end

    // R10 reset again clears state and id flag
    rst = 1; step(); rst = 0; @(negedge clk);
    rd(2, v); chk("R10 id flag cleared", v, ID);
    chk("R10 tc", tc, 0);
    finish_run();
  end
endmodule